// File: doc/BRIEF.md
# Multi-Channel Limit Monitor

This block watches a set of digitized measurement channels and compares every new result against four user-programmed limits per channel. By default there are five channels: a temperature channel, a supply-voltage channel and three external inputs. A converter outside the block delivers one 16-bit result per channel and pulses that channel's strobe whenever a new result is ready. The block keeps the latest result, a four-bit limit-flag set and a conversion-done bit for each channel.

Software uses a small synchronous read/write register bus to program the limits and the per-flag interrupt enables, read the flags and the stored samples, and collect the conversion-done bits. Reading the done bits clears them. Two outputs go to the rest of the system:

- An interrupt line that is high while any enabled flag is set.
- An active-low fault line for any alarm-level violation, driven only when the fault function is switched on.

By default the temperature channel is compared as two's-complement. All other channels are compared as unsigned.

Top module: `limit_monitor`

## Requirements
- R1: After reset all flags, done bits, interrupt enables and the fault-enable bit are zero, `irq` is 0 and `fault_n` is 1. Each high limit resets to the largest value of its channel's number format (7FFFh signed, FFFFh unsigned). Each low limit resets to the smallest (8000h signed, 0000h unsigned).
- R2: The flag word of a channel holds four bits, all from strict comparisons:
  - bit 0: sample > high alarm limit
  - bit 1: sample < low alarm limit
  - bit 2: sample > high warning limit
  - bit 3: sample < low warning limit
- R3: Channel 0 (temperature) compares the sample and its limits as two's-complement numbers. All other channels compare them as unsigned numbers.
- R4: A channel's flags are replaced as a whole at the clock edge that samples its strobe, using the sample presented with that strobe. Flags of a channel with no strobe keep their value.
- R5: A strobe sets the channel's done bit at the same edge. A read of the done register returns the done bits in bits [NUM_CH-1:0] and clears them. A strobe in the same cycle as that read leaves its bit set.
- R6: `irq` is 1 exactly when, for some channel, the AND of its flag word and its 4-bit enable mask is non-zero. Bit positions in the mask match the flag bits.
- R7: `fault_n` is 0 exactly when the fault-enable bit (bit 0 of the control register) is 1 and some channel has flag bit 0 or 1 set. It ignores interrupt enables and warning flags.
- R8: Register addresses are `{slot[2:0], offset[2:0]}`.
  - Channel slots 0 to NUM_CH-1 use these offsets: 0 high alarm, 1 low alarm, 2 high warning, 3 low warning, 4 latest sample (read-only), 5 flags (read-only), 6 interrupt enable mask.
  - Slot 7 holds offset 0, the done register, and offset 1, the control register.
  - Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
  - A limit write changes no flags until the channel's next strobe.
- R9: Offset 4 of a channel returns the sample taken with its most recent strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | NUM_CH | Per-channel new-result strobe |
| smp_data | input | NUM_CH*DATA_W | Results, channel i at bits [i*DATA_W +: DATA_W] |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Register address {slot, offset} |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Enabled-flag interrupt |
| fault_n | output | 1 | Active-low alarm fault |

## Verification
Each channel is swept with samples one below, on and one above each of its four limits, plus the extreme codes 0000h, 7FFFh, 8000h and FFFFh. Points on a limit separate strict from inclusive comparison. The extremes separate signed from unsigned handling on the temperature channel and the other channels. The interrupt mask during the sweep enables only the high-warning bit, and the fault output is on. This setting makes the interrupt and fault outputs follow different flag subsets, and their expected values are recomputed after every strobe from the flags of all channels. Separate patterns cover:
- A done read that coincides with a strobe.
- A limit write with no strobe after it.
- A fault output switched off while an alarm is present.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

   localparam int FLG_W = 4;

   // flag bit positions
   localparam int FLG_HI_ALM = 0;
   localparam int FLG_LO_ALM = 1;
   localparam int FLG_HI_WRN = 2;
   localparam int FLG_LO_WRN = 3;

   // per-channel register offsets
   localparam logic [2:0] OFS_HI_ALM = 3'd0;
   localparam logic [2:0] OFS_LO_ALM = 3'd1;
   localparam logic [2:0] OFS_HI_WRN = 3'd2;
   localparam logic [2:0] OFS_LO_WRN = 3'd3;
   localparam logic [2:0] OFS_SAMPLE = 3'd4;
   localparam logic [2:0] OFS_FLAGS  = 3'd5;
   localparam logic [2:0] OFS_IEN    = 3'd6;

   // global slot
   localparam logic [2:0] GLB_SLOT   = 3'd7;
   localparam logic [2:0] GOFS_DONE  = 3'd0;
   localparam logic [2:0] GOFS_CTRL  = 3'd1;

   typedef struct packed {
      logic lo_wrn;
      logic hi_wrn;
      logic lo_alm;
      logic hi_alm;
   } flags_t;

endpackage

// File: rtl/lmon_cmp.sv
module lmon_cmp #(
   parameter int DATA_W     = 16,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic [DATA_W-1:0] sample,
   input  logic [DATA_W-1:0] hi_alm,
   input  logic [DATA_W-1:0] lo_alm,
   input  logic [DATA_W-1:0] hi_wrn,
   input  logic [DATA_W-1:0] lo_wrn,
   output lmon_pkg::flags_t  flags
);

   generate
      if (SIGNED_CMP) begin : g_signed
         always_comb begin
            flags.hi_alm = $signed(sample) > $signed(hi_alm);
            flags.lo_alm = $signed(sample) < $signed(lo_alm);
            flags.hi_wrn = $signed(sample) > $signed(hi_wrn);
            flags.lo_wrn = $signed(sample) < $signed(lo_wrn);
         end
      end else begin : g_unsigned
         always_comb begin
            flags.hi_alm = sample > hi_alm;
            flags.lo_alm = sample < lo_alm;
            flags.hi_wrn = sample > hi_wrn;
            flags.lo_wrn = sample < lo_wrn;
         end
      end
   endgenerate

endmodule

// File: rtl/lmon_channel.sv
module lmon_channel #(
   parameter int DATA_W     = 16,
   parameter bit SIGNED_CMP = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_vld,
   input  logic [DATA_W-1:0] smp_data,
   input  logic              wr_en,
   input  logic [2:0]        ofs,
   input  logic [DATA_W-1:0] wdata,
   output lmon_pkg::flags_t  flags_q,
   output logic [lmon_pkg::FLG_W-1:0] ien_q,
   output logic [DATA_W-1:0] rd_word
);
   import lmon_pkg::*;

   localparam int NUM_LIM = 4;
   localparam logic [DATA_W-1:0] MAX_V = SIGNED_CMP ? {1'b0, {(DATA_W-1){1'b1}}} : {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] MIN_V = SIGNED_CMP ? {1'b1, {(DATA_W-1){1'b0}}} : {DATA_W{1'b0}};

   logic [DATA_W-1:0] lim_q [NUM_LIM];
   logic [DATA_W-1:0] sample_q;
   flags_t            cmp_flags;

   // limit registers: even index is a high limit, odd a low limit
   generate
      for (genvar l = 0; l < NUM_LIM; l++) begin : g_lim
         localparam logic [DATA_W-1:0] RST_V = (l % 2 == 0) ? MAX_V : MIN_V;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lim_q[l] <= RST_V;
            end else if (wr_en && ofs == 3'(l)) begin
               lim_q[l] <= wdata;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_q <= '0;
      end else if (wr_en && ofs == OFS_IEN) begin
         ien_q <= wdata[FLG_W-1:0];
      end
   end

   lmon_cmp #(
      .DATA_W     (DATA_W),
      .SIGNED_CMP (SIGNED_CMP)
   ) u_cmp (
      .sample (smp_data),
      .hi_alm (lim_q[OFS_HI_ALM]),
      .lo_alm (lim_q[OFS_LO_ALM]),
      .hi_wrn (lim_q[OFS_HI_WRN]),
      .lo_wrn (lim_q[OFS_LO_WRN]),
      .flags  (cmp_flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         flags_q  <= '0;
      end else if (smp_vld) begin
         sample_q <= smp_data;
         flags_q  <= cmp_flags;
      end
   end

   always_comb begin
      rd_word = '0;
      case (ofs)
         OFS_HI_ALM: rd_word = lim_q[OFS_HI_ALM];
         OFS_LO_ALM: rd_word = lim_q[OFS_LO_ALM];
         OFS_HI_WRN: rd_word = lim_q[OFS_HI_WRN];
         OFS_LO_WRN: rd_word = lim_q[OFS_LO_WRN];
         OFS_SAMPLE: rd_word = sample_q;
         OFS_FLAGS:  rd_word = DATA_W'(flags_q);
         OFS_IEN:    rd_word = DATA_W'(ien_q);
         default:    rd_word = '0;
      endcase
   end

endmodule

// File: rtl/lmon_global.sv
module lmon_global #(
   parameter int NUM_CH = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_CH-1:0]              smp_vld,
   input  logic                           done_rd,
   input  logic                           ctrl_wr,
   input  logic                           ctrl_fault_en,
   input  logic [NUM_CH*lmon_pkg::FLG_W-1:0] flag_vec,
   input  logic [NUM_CH*lmon_pkg::FLG_W-1:0] ien_vec,
   output logic [NUM_CH-1:0]              done_q,
   output logic                           fault_en_q,
   output logic                           irq,
   output logic                           fault_n
);
   import lmon_pkg::*;

   logic [NUM_CH-1:0] ch_irq;
   logic [NUM_CH-1:0] ch_alm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= '0;
      end else begin
         done_q <= (done_rd ? '0 : done_q) | smp_vld;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_en_q <= 1'b0;
      end else if (ctrl_wr) begin
         fault_en_q <= ctrl_fault_en;
      end
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign ch_irq[c] = |(flag_vec[c*FLG_W +: FLG_W] & ien_vec[c*FLG_W +: FLG_W]);
         assign ch_alm[c] = flag_vec[c*FLG_W + FLG_HI_ALM] | flag_vec[c*FLG_W + FLG_LO_ALM];
      end
   endgenerate

   assign irq     = |ch_irq;
   assign fault_n = ~(fault_en_q & (|ch_alm));

endmodule

// File: rtl/limit_monitor.sv
module limit_monitor #(
   parameter int          NUM_CH      = 5,
   parameter int          DATA_W      = 16,
   parameter logic [31:0] SIGNED_MASK = 32'h0000_0001
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        smp_vld,
   input  logic [NUM_CH*DATA_W-1:0] smp_data,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [5:0]               bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     irq,
   output logic                     fault_n
);
   import lmon_pkg::*;

   localparam int SLOT_W = 3;
   localparam int FV_W   = NUM_CH * FLG_W;

   generate
      if (NUM_CH < 1 || NUM_CH > 7) begin : g_bad_nch
         $error("limit_monitor: NUM_CH must be 1..7");
      end
      if (DATA_W < 8 || DATA_W > 32) begin : g_bad_dw
         $error("limit_monitor: DATA_W must be 8..32");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic [2:0]        ofs;
   logic [DATA_W-1:0] ch_word [NUM_CH];
   logic [FV_W-1:0]   flag_vec;
   logic [FV_W-1:0]   ien_vec;
   logic [NUM_CH-1:0] done_q;
   logic              fault_en_q;
   logic              done_rd;
   logic              ctrl_wr;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;

   assign slot    = bus_addr[5:3];
   assign ofs     = bus_addr[2:0];
   assign done_rd = bus_rd && slot == GLB_SLOT && ofs == GOFS_DONE;
   assign ctrl_wr = bus_wr && slot == GLB_SLOT && ofs == GOFS_CTRL;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         flags_t           fl;
         logic [FLG_W-1:0] en;
         logic             sel_wr;

         assign sel_wr = bus_wr && slot == SLOT_W'(c);

         lmon_channel #(
            .DATA_W     (DATA_W),
            .SIGNED_CMP (SIGNED_MASK[c])
         ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .smp_vld  (smp_vld[c]),
            .smp_data (smp_data[c*DATA_W +: DATA_W]),
            .wr_en    (sel_wr),
            .ofs      (ofs),
            .wdata    (bus_wdata),
            .flags_q  (fl),
            .ien_q    (en),
            .rd_word  (ch_word[c])
         );

         assign flag_vec[c*FLG_W +: FLG_W] = fl;
         assign ien_vec[c*FLG_W +: FLG_W]  = en;
      end
   endgenerate

   lmon_global #(
      .NUM_CH (NUM_CH)
   ) u_glb (
      .clk           (clk),
      .rst_n         (rst_n),
      .smp_vld       (smp_vld),
      .done_rd       (done_rd),
      .ctrl_wr       (ctrl_wr),
      .ctrl_fault_en (bus_wdata[0]),
      .flag_vec      (flag_vec),
      .ien_vec       (ien_vec),
      .done_q        (done_q),
      .fault_en_q    (fault_en_q),
      .irq           (irq),
      .fault_n       (fault_n)
   );

   always_comb begin
      rd_mux = '0;
      if (slot == GLB_SLOT) begin
         case (ofs)
            GOFS_DONE: rd_mux = DATA_W'(done_q);
            GOFS_CTRL: rd_mux = DATA_W'(fault_en_q);
            default:   rd_mux = '0;
         endcase
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (slot == SLOT_W'(c)) rd_mux = ch_word[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (bus_rd) begin
         rdata_q <= rd_mux;
      end
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/limit_monitor_checker.sv
module limit_monitor_checker #(
   parameter int NUM_CH = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [NUM_CH-1:0]     smp_vld,
   input logic [NUM_CH*4-1:0]   flag_vec,
   input logic [NUM_CH*4-1:0]   ien_vec,
   input logic [NUM_CH-1:0]     done_q,
   input logic                  fault_en_q,
   input logic                  irq,
   input logic                  fault_n
);

   AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld == '0) |=> $stable(flag_vec)); // R4

   AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld != '0) |=> ((done_q & $past(smp_vld)) == $past(smp_vld))); // R5

   AST_DONE_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld == '0) |=> ((done_q & ~$past(done_q)) == '0)); // R5

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_vec & ien_vec) == '0) |-> !irq); // R6

   AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      ((flag_vec & ien_vec) != '0) |-> irq); // R6

   AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_en_q |-> fault_n); // R7

endmodule

bind limit_monitor limit_monitor_checker #(
   .NUM_CH (NUM_CH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_vld    (smp_vld),
   .flag_vec   (flag_vec),
   .ien_vec    (ien_vec),
   .done_q     (done_q),
   .fault_en_q (fault_en_q),
   .irq        (irq),
   .fault_n    (fault_n)
);

// File: tb/limit_monitor_bench.sv
`timescale 1ns/1ps
module limit_monitor_bench;
   localparam int NCH = 5;
   localparam int DW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [NCH-1:0]    smp_vld = '0;
   logic [NCH*DW-1:0] smp_data = '0;
   logic              bus_wr = 1'b0;
   logic              bus_rd = 1'b0;
   logic [5:0]        bus_addr = '0;
   logic [DW-1:0]     bus_wdata = '0;
   logic [DW-1:0]     bus_rdata;
   logic              irq;
   logic              fault_n;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   logic [15:0] thr  [NCH][4];
   logic [3:0]  expf [NCH];
   logic [3:0]  ienc [NCH];
   bit          fen = 1'b0;

   limit_monitor u_limit_monitor (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .fault_n(fault_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [15:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 6'(a);
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [3:0] calc(input int c, input logic [15:0] v);
      logic [3:0] f;
      if (c == 0) begin
         f[0] = $signed(v) > $signed(thr[c][0]);
         f[1] = $signed(v) < $signed(thr[c][1]);
         f[2] = $signed(v) > $signed(thr[c][2]);
         f[3] = $signed(v) < $signed(thr[c][3]);
      end else begin
         f[0] = v > thr[c][0];
         f[1] = v < thr[c][1];
         f[2] = v > thr[c][2];
         f[3] = v < thr[c][3];
      end
      return f;
   endfunction

   function automatic logic exp_irq();
      logic r = 1'b0;
      for (int c = 0; c < NCH; c++) r |= |(expf[c] & ienc[c]);
      return r;
   endfunction

   function automatic logic exp_fault_n();
      logic a = 1'b0;
      for (int c = 0; c < NCH; c++) a |= expf[c][0] | expf[c][1];
      return !(fen && a);
   endfunction

   task automatic strobe(input int c, input logic [15:0] v);
      @(negedge clk);
      smp_vld[c] = 1'b1;
      smp_data[c*DW +: DW] = v;
      @(negedge clk);
      smp_vld = '0;
      expf[c] = calc(c, v);
   endtask

   task automatic set_thr(input int c, input int l, input logic [15:0] v);
      wr(c*8 + l, v);
      thr[c][l] = v;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [15:0] extras [4];
      extras[0] = 16'h0000; extras[1] = 16'hFFFF;
      extras[2] = 16'h8000; extras[3] = 16'h7FFF;
      for (int c = 0; c < NCH; c++) begin
         thr[c][0] = (c == 0) ? 16'h7FFF : 16'hFFFF;
         thr[c][1] = (c == 0) ? 16'h8000 : 16'h0000;
         thr[c][2] = thr[c][0];
         thr[c][3] = thr[c][1];
         expf[c] = '0;
         ienc[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", irq, 0);
      check("R1 fault_n", fault_n, 1);
      rd(0, d);  check("R1 ch0 high alarm signed max", d, 16'h7FFF);
      rd(1, d);  check("R1 ch0 low alarm signed min", d, 16'h8000);
      rd(8, d);  check("R1 ch1 high alarm unsigned max", d, 16'hFFFF);
      rd(11, d); check("R1 ch1 low warning unsigned min", d, 16'h0000);
      rd(56, d); check("R1 done bits", d, 0);
      rd(57, d); check("R1 fault enable", d, 0);
      rd(5, d);  check("R1 ch0 flags", d, 0);
      rd(14, d); check("R1 ch1 enable mask", d, 0);

      // program limits, enable only high-warning interrupts, fault on
      for (int c = 0; c < NCH; c++) begin
         if (c == 0) begin
            set_thr(c, 0, 16'd50);
            set_thr(c, 1, 16'hFFE2);
            set_thr(c, 2, 16'd40);
            set_thr(c, 3, 16'hFFEC);
         end else begin
            set_thr(c, 0, 16'(1000 + c));
            set_thr(c, 1, 16'(100 + c));
            set_thr(c, 2, 16'd800);
            set_thr(c, 3, 16'd200);
         end
         wr(c*8 + 6, 16'h0004);
         ienc[c] = 4'b0100;
      end
      wr(57, 16'h0001);
      fen = 1'b1;

      // sweep each channel around every limit and the extreme codes
      for (int c = 0; c < NCH; c++) begin
         for (int k = 0; k < 16; k++) begin
            logic [15:0] v;
            v = (k < 12) ? 16'(thr[c][k/3] + 16'(k%3) - 16'd1) : extras[k-12];
            strobe(c, v);
            check("R6 irq after strobe", irq, exp_irq());
            check("R7 fault_n after strobe", fault_n, exp_fault_n());
            rd(c*8 + 5, d);
            if (c == 0) check("R3 signed flags", d, 16'(expf[c]));
            else        check("R2 unsigned flags", d, 16'(expf[c]));
            if (k == 5) begin
               rd(c*8 + 4, d);
               check("R9 latest sample", d, v);
            end
         end
      end

      // R4: every channel's flags still match its own last sample
      for (int c = 0; c < NCH; c++) begin
         rd(c*8 + 5, d);
         check("R4 flags kept", d, 16'(expf[c]));
      end

      // R5: done bits, clear on read, strobe racing a read
      rd(56, d); check("R5 all done set", d, 16'h001F);
      rd(56, d); check("R5 done cleared by read", d, 0);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 6'd56;
      smp_vld[3] = 1'b1; smp_data[3*DW +: DW] = 16'd500;
      @(negedge clk);
      bus_rd = 1'b0; smp_vld = '0;
      expf[3] = calc(3, 16'd500);
      check("R5 read during strobe returns old", bus_rdata, 0);
      rd(56, d); check("R5 racing strobe kept", d, 16'h0008);
      strobe(2, 16'd500);
      rd(56, d); check("R5 single strobe", d, 16'h0004);

      // R8: limit write acts only at next strobe
      strobe(1, 16'd500);
      rd(13, d); check("R8 ch1 flags quiet", d, 0);
      set_thr(1, 0, 16'd10);
      rd(13, d); check("R8 limit write no effect", d, 0);
      rd(8, d);  check("R8 limit readback", d, 16'd10);
      check("R8 read data held", bus_rdata, 16'd10);
      strobe(1, 16'd500);
      rd(13, d); check("R8 flags after next strobe", d, 16'h0001);

      // R6 / R7: enables and fault control
      for (int c = 0; c < NCH; c++) begin
         wr(c*8 + 6, 16'h0000);
         ienc[c] = '0;
      end
      check("R6 irq all masked", irq, 0);
      check("R7 alarm with fault on", fault_n, 0);
      wr(14, 16'h0001);
      ienc[1] = 4'b0001;
      check("R6 irq on hi alarm enable", irq, exp_irq());
      wr(57, 16'h0000);
      fen = 1'b0;
      check("R7 fault off", fault_n, 1);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule